// File: doc/BRIEF.md
# PWM Periodic Compare Event Unit

This unit watches the counter of a reference PWM channel and produces a one-clock compare event when that counter equals a programmed value. The event can be restricted to one selected period out of a programmable cycle of periods. When the reference channel runs centre-aligned, the event can also be restricted to the rising or the falling half of the count. An active fault on the reference channel suppresses the event completely.

Software never writes the active settings directly. It writes a value shadow (compare value and direction) and a configuration shadow (enable, period selection, update period). Writing the configuration shadow marks an update as pending. A pending update is copied into the active registers at the end of a programmable number of reference periods. While the unit is disabled, the copy happens on the next clock instead. Both the compare event and the update event set status bits. The interrupt line reports these bits through a software-controlled mask.

Top module: `pwm_cmp_event`

## Requirements
- R1: When the active enable bit is 1, the compare is armed and the direction rule holds, a clock with `cnt_i` equal to the active compare value produces a one-clock pulse on `match_o` after the next rising edge. With the enable bit at 0, `match_o` stays 0.
- R2: When `centre_i` is 1, the active direction bit selects the match phase: 0 matches only while `cnt_down_i` is 0, and 1 matches only while `cnt_down_i` is 1. When `centre_i` is 0, the direction bit and `cnt_down_i` have no effect.
- R3: While `fault_i` is 1, no match is taken.
- R4: A compare-period counter restarts at 0 on every commit. It advances on each `eop_i` and wraps to 0 after reaching the active limit field. The compare is armed only while this counter equals the active trigger field. So in the p-th period after a commit (p from 0), a match can occur only if p mod (limit+1) equals the trigger. With limit = trigger = 0, every period is armed.
- R5: If `cnt_i` stays equal to the compare value for several clocks, only one pulse is produced.
- R6: An update counter restarts at 0 on every commit and advances on each `eop_i`. A pending update commits at the `eop_i` clock on which this counter equals the active update-period field, or on the clock after the pending flag is set if the active enable bit is 0. A commit copies both shadows into the active registers and pulses `upd_o` once after that edge.
- R7: A write to the value shadow alone leaves the active value unchanged, even across update points. A write to the configuration shadow is what makes an update pending, and the next commit then also carries the latest value shadow.
- R8: Writing address 2 sets the mask bits given by `wdata_i[1:0]`, and writing address 3 clears them. Mask bit 0 is match and bit 1 is update. `irq_o` is 1 when any status bit is 1 together with its mask bit.
- R9: Status bit 0 is set by a match pulse and bit 1 by an update pulse. Reading address 4 returns the status and clears it, but a new event in the same clock wins over the clear.
- R10: After reset, `match_o`, `upd_o` and `irq_o` are 0, and all active registers read 0.
- Register layout (PW = 4, CW = 16): address 0 writes the config shadow and address 1 writes the value shadow. Addresses 5, 6 and 7 read the active config, the active value and the mask.
- The config word has enable at bit 0, the trigger at [4:1], the limit at [8:5] and the update period at [12:9].
- The value word has the compare value at [15:0] and the direction bit at bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CW | Reference channel counter value |
| cnt_down_i | input | 1 | Reference counter is counting down |
| centre_i | input | 1 | Reference channel is centre-aligned |
| eop_i | input | 1 | One-clock end-of-period strobe of the reference channel |
| fault_i | input | 1 | Fault active on the reference channel |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address for both read and write |
| wdata_i | input | CW+1 | Write data |
| rdata_o | output | CW+1 | Read data for `addr_i`, combinational |
| match_o | output | 1 | Compare event pulse |
| upd_o | output | 1 | Update-committed pulse |
| irq_o | output | 1 | Masked interrupt request |

## Verification
A compare-period counter that is out of step moves the match into the wrong period. This shows as a wrong match count within one period cycle after a commit. An update counter or pending flag in the wrong state moves `upd_o` to a different end-of-period strobe, or leaves stale values in the active readback. Both show within one update cycle. A stuck status or mask bit shows on `irq_o` immediately, and on the next status read.

// File: rtl/pwm_cmp_pkg.sv
`timescale 1ns/1ps
package pwm_cmp_pkg;
  localparam logic [2:0] A_CFG  = 3'd0;
  localparam logic [2:0] A_VAL  = 3'd1;
  localparam logic [2:0] A_IEN  = 3'd2;
  localparam logic [2:0] A_IDIS = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;
  localparam logic [2:0] A_ACFG = 3'd5;
  localparam logic [2:0] A_AVAL = 3'd6;
  localparam logic [2:0] A_MASK = 3'd7;
  localparam int EV_MATCH = 0;
  localparam int EV_UPD   = 1;
  localparam int NEV      = 2;
endpackage

// File: rtl/cmp_period_ctr.sv
`timescale 1ns/1ps
module cmp_period_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] lim,
  output logic [W-1:0] cnt
);
  function automatic logic [W-1:0] wrap_next(input logic [W-1:0] c, input logic [W-1:0] l);
    return (c >= l) ? '0 : c + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= wrap_next(cnt, lim);
  end

  // R4
  within_lim_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= lim);
endmodule

// File: rtl/cmp_shadow.sv
`timescale 1ns/1ps
module cmp_shadow #(
  parameter int CW = 16,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cfg,
  input  logic          wr_val,
  input  logic [CW:0]   wdata,
  input  logic          commit,
  output logic          pending,
  output logic          act_en,
  output logic [PW-1:0] act_ctr,
  output logic [PW-1:0] act_cpr,
  output logic [PW-1:0] act_cupr,
  output logic [CW-1:0] act_cv,
  output logic          act_cvm
);
  localparam int CTR_LSB  = 1;
  localparam int CPR_LSB  = 1 + PW;
  localparam int CUPR_LSB = 1 + 2 * PW;

  logic          sh_en, sh_cvm;
  logic [PW-1:0] sh_ctr, sh_cpr, sh_cupr;
  logic [CW-1:0] sh_cv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_en <= 1'b0; sh_ctr <= '0; sh_cpr <= '0; sh_cupr <= '0;
      sh_cv <= '0; sh_cvm <= 1'b0;
    end else begin
      if (wr_cfg) begin
        sh_en   <= wdata[0];
        sh_ctr  <= wdata[CTR_LSB +: PW];
        sh_cpr  <= wdata[CPR_LSB +: PW];
        sh_cupr <= wdata[CUPR_LSB +: PW];
      end
      if (wr_val) begin
        sh_cv  <= wdata[CW-1:0];
        sh_cvm <= wdata[CW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      pending <= 1'b0;
    else if (wr_cfg) pending <= 1'b1;
    else if (commit) pending <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_en <= 1'b0; act_ctr <= '0; act_cpr <= '0; act_cupr <= '0;
      act_cv <= '0; act_cvm <= 1'b0;
    end else if (commit) begin
      act_en <= sh_en; act_ctr <= sh_ctr; act_cpr <= sh_cpr; act_cupr <= sh_cupr;
      act_cv <= sh_cv; act_cvm <= sh_cvm;
    end
  end

  // R7
  pending_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(wr_cfg));
endmodule

// File: rtl/cmp_irq.sv
`timescale 1ns/1ps
module cmp_irq #(
  parameter int NE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] ev,
  input  logic          mask_set,
  input  logic          mask_clr,
  input  logic [NE-1:0] wbits,
  input  logic          rd_stat,
  output logic [NE-1:0] status,
  output logic [NE-1:0] mask,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)        mask <= '0;
    else if (mask_set) mask <= mask | wbits;
    else if (mask_clr) mask <= mask & ~wbits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (rd_stat ? '0 : status) | ev;
  end

  assign irq = |(status & mask);

  // R8
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) (mask == '0) |-> !irq);
  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && ev == '0) |=> status == '0);
endmodule

// File: rtl/pwm_cmp_event.sv
`timescale 1ns/1ps
module pwm_cmp_event #(
  parameter int CW = 16,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic          cnt_down_i,
  input  logic          centre_i,
  input  logic          eop_i,
  input  logic          fault_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [2:0]    addr_i,
  input  logic [CW:0]   wdata_i,
  output logic [CW:0]   rdata_o,
  output logic          match_o,
  output logic          upd_o,
  output logic          irq_o
);
  import pwm_cmp_pkg::*;

  localparam int CTR_LSB  = 1;
  localparam int CPR_LSB  = 1 + PW;
  localparam int CUPR_LSB = 1 + 2 * PW;

  logic          pending, act_en, act_cvm;
  logic [PW-1:0] act_ctr, act_cpr, act_cupr, per_cnt, upd_cnt;
  logic [CW-1:0] act_cv;
  logic [NEV-1:0] status, mask, ev;

  // named internal events
  logic upd_point, commit, armed, dir_ok, hit, hit_q, match_edge, cnt_clr;

  assign upd_point  = eop_i && (upd_cnt == act_cupr);
  assign commit     = pending && (!act_en || upd_point);
  assign cnt_clr    = !act_en || commit;
  assign armed      = (per_cnt == act_ctr);
  assign dir_ok     = !centre_i || (cnt_down_i == act_cvm);
  assign hit        = act_en && !fault_i && armed && dir_ok && (cnt_i == act_cv);
  assign match_edge = hit && !hit_q;

  cmp_shadow #(.CW(CW), .PW(PW)) u_shadow (
    .clk(clk), .rst_n(rst_n),
    .wr_cfg(wr_en_i && addr_i == A_CFG), .wr_val(wr_en_i && addr_i == A_VAL),
    .wdata(wdata_i), .commit(commit), .pending(pending),
    .act_en(act_en), .act_ctr(act_ctr), .act_cpr(act_cpr), .act_cupr(act_cupr),
    .act_cv(act_cv), .act_cvm(act_cvm)
  );

  cmp_period_ctr #(.W(PW)) u_per_ctr (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .step(eop_i), .lim(act_cpr), .cnt(per_cnt)
  );

  cmp_period_ctr #(.W(PW)) u_upd_ctr (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .step(eop_i), .lim(act_cupr), .cnt(upd_cnt)
  );

  always_comb begin
    ev = '0;
    ev[EV_MATCH] = match_edge;
    ev[EV_UPD]   = commit;
  end

  cmp_irq #(.NE(NEV)) u_irq (
    .clk(clk), .rst_n(rst_n), .ev(ev),
    .mask_set(wr_en_i && addr_i == A_IEN), .mask_clr(wr_en_i && addr_i == A_IDIS),
    .wbits(wdata_i[NEV-1:0]), .rd_stat(rd_en_i && addr_i == A_STAT),
    .status(status), .mask(mask), .irq(irq_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= 1'b0; match_o <= 1'b0; upd_o <= 1'b0;
    end else begin
      hit_q <= hit; match_o <= match_edge; upd_o <= commit;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_STAT: rdata_o[NEV-1:0] = status;
      A_MASK: rdata_o[NEV-1:0] = mask;
      A_ACFG: begin
        rdata_o[0]                = act_en;
        rdata_o[CTR_LSB +: PW]    = act_ctr;
        rdata_o[CPR_LSB +: PW]    = act_cpr;
        rdata_o[CUPR_LSB +: PW]   = act_cupr;
      end
      A_AVAL: rdata_o = {act_cvm, act_cv};
      default: rdata_o = '0;
    endcase
  end

  // R1
  match_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> $past(act_en));
  // R3
  fault_block_chk: assert property (@(posedge clk) disable iff (!rst_n) fault_i |=> !match_o);
  // R5
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n) match_o |=> !match_o);
  // R6
  upd_from_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> $past(pending));
endmodule

// File: tb/pwm_cmp_event_test.sv
`timescale 1ns/1ps
module pwm_cmp_event_test;
  localparam int CW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] cnt_i = '0;
  logic cnt_down_i = 0, centre_i = 0, eop_i = 0, fault_i = 0, wr_en_i = 0, rd_en_i = 0;
  logic [2:0] addr_i = '0;
  logic [CW:0] wdata_i = '0, rdata_o, rd;
  logic match_o, upd_o, irq_o;
  int checks = 0, errs = 0, mcount = 0, ucount = 0, m0, u0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_cmp_event uut (.*);

  always @(posedge clk) if (rst_n) begin
    mcount <= mcount + int'(match_o);
    ucount <= ucount + int'(upd_o);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [CW:0] cfgw(int en, int ctr, int cpr, int cupr);
    return (CW+1)'(en + ctr * 2 + cpr * 32 + cupr * 512);
  endfunction
  function automatic logic [CW:0] valw(int cv, int dir);
    return (CW+1)'(cv + dir * 65536);
  endfunction

  task automatic wr(input logic [2:0] a, input logic [CW:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1;
    @(posedge clk); @(negedge clk); wr_en_i = 0;
  endtask
  task automatic rdreg(input logic [2:0] a, output logic [CW:0] d);
    addr_i = a; rd_en_i = 1; #1 d = rdata_o;
    @(posedge clk); @(negedge clk); rd_en_i = 0;
  endtask
  task automatic cyc(input int c, input bit dn, input bit e, input bit f);
    cnt_i = CW'(c); cnt_down_i = dn; eop_i = e; fault_i = f;
    @(posedge clk); @(negedge clk);
  endtask
  task automatic idle();
    cnt_i = CW'(9); cnt_down_i = 0; eop_i = 0; fault_i = 0;
  endtask
  task automatic lperiod(input bit f, input bit dn);
    for (int i = 0; i < 6; i++) cyc(i, dn, i == 5, f);
    idle();
  endtask
  task automatic flush();
    cyc(9, 0, 1, 0); cyc(9, 0, 0, 0); idle();
  endtask
  task automatic setcfg(input int cv, input int dir, input int ctr, input int cpr);
    wr(pwm_cmp_pkg::A_VAL, valw(cv, dir));
    wr(pwm_cmp_pkg::A_CFG, cfgw(1, ctr, cpr, 0));
    flush();
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 match", int'(match_o), 0);
    chk("R10 upd", int'(upd_o), 0);
    chk("R10 irq", int'(irq_o), 0);
    rdreg(pwm_cmp_pkg::A_ACFG, rd); chk("R10 acfg", int'(rd), 0);
    rdreg(pwm_cmp_pkg::A_AVAL, rd); chk("R10 aval", int'(rd), 0);

    // R6 immediate commit while disabled
    u0 = ucount;
    wr(pwm_cmp_pkg::A_VAL, valw(3, 0));
    wr(pwm_cmp_pkg::A_CFG, cfgw(1, 0, 0, 0));
    cyc(9, 0, 0, 0); cyc(9, 0, 0, 0);
    chk("R6 immediate upd", ucount - u0, 1);
    rdreg(pwm_cmp_pkg::A_ACFG, rd); chk("R6 acfg", int'(rd), int'(cfgw(1, 0, 0, 0)));

    // R4 sweep of limit and trigger, R1 match on equality
    for (int cpr = 0; cpr < 3; cpr++)
      for (int ctr = 0; ctr < 4; ctr++) begin
        u0 = ucount;
        setcfg(3, 0, ctr, cpr);
        chk("R6 commit at eop", ucount - u0, 1);
        for (int p = 0; p < 6; p++) begin
          m0 = mcount;
          lperiod(0, 0);
          chk($sformatf("R4 cpr=%0d ctr=%0d p=%0d", cpr, ctr, p), mcount - m0,
              ((p % (cpr + 1)) == ctr) ? 1 : 0);
        end
      end
    setcfg(3, 0, 0, 0);

    // R5 held equality
    m0 = mcount;
    for (int i = 0; i < 4; i++) cyc(3, 0, 0, 0);
    cyc(9, 0, 0, 0); idle();
    chk("R5 single pulse", mcount - m0, 1);

    // R3 fault
    m0 = mcount; lperiod(1, 0); chk("R3 fault blocks", mcount - m0, 0);
    m0 = mcount; lperiod(0, 0); chk("R3 after fault", mcount - m0, 1);

    // R2 left-aligned ignores direction
    m0 = mcount; lperiod(0, 1); chk("R2 left dir=0 down", mcount - m0, 1);
    setcfg(3, 1, 0, 0);
    m0 = mcount; lperiod(0, 0); chk("R2 left dir=1 up", mcount - m0, 1);

    // R2 centre-aligned phases
    for (int d = 0; d < 2; d++) begin
      setcfg(3, d, 0, 0);
      centre_i = 1;
      m0 = mcount;
      for (int i = 0; i < 6; i++) cyc(i, 0, 0, 0);
      chk($sformatf("R2 centre dir=%0d up", d), mcount - m0, d == 0 ? 1 : 0);
      m0 = mcount;
      for (int i = 4; i >= 0; i--) cyc(i, 1, i == 0, 0);
      cyc(9, 0, 0, 0); idle();
      chk($sformatf("R2 centre dir=%0d down", d), mcount - m0, d == 1 ? 1 : 0);
      centre_i = 0;
    end
    setcfg(3, 0, 0, 0);

    // R7 value shadow alone does not commit
    wr(pwm_cmp_pkg::A_VAL, valw(2, 0));
    flush();
    rdreg(pwm_cmp_pkg::A_AVAL, rd); chk("R7 aval unchanged", int'(rd), int'(valw(3, 0)));
    m0 = mcount; lperiod(0, 0); chk("R7 old value matches", mcount - m0, 1);
    wr(pwm_cmp_pkg::A_CFG, cfgw(1, 0, 0, 0));
    flush();
    rdreg(pwm_cmp_pkg::A_AVAL, rd); chk("R7 aval after cfg", int'(rd), int'(valw(2, 0)));

    // R6 update period of 2
    wr(pwm_cmp_pkg::A_CFG, cfgw(1, 0, 0, 2));
    flush();
    u0 = ucount;
    wr(pwm_cmp_pkg::A_VAL, valw(4, 0));
    wr(pwm_cmp_pkg::A_CFG, cfgw(1, 0, 0, 2));
    cyc(9, 0, 1, 0); cyc(9, 0, 1, 0); idle(); cyc(9, 0, 0, 0);
    chk("R6 no commit before third eop", ucount - u0, 0);
    rdreg(pwm_cmp_pkg::A_AVAL, rd); chk("R6 aval held", int'(rd), int'(valw(2, 0)));
    cyc(9, 0, 1, 0); idle(); cyc(9, 0, 0, 0);
    chk("R6 commit on third eop", ucount - u0, 1);
    rdreg(pwm_cmp_pkg::A_AVAL, rd); chk("R6 aval new", int'(rd), int'(valw(4, 0)));
    wr(pwm_cmp_pkg::A_VAL, valw(3, 0));
    wr(pwm_cmp_pkg::A_CFG, cfgw(1, 0, 0, 0));
    for (int i = 0; i < 3; i++) cyc(9, 0, 1, 0);
    idle(); cyc(9, 0, 0, 0);

    // R8 / R9 interrupts and status
    rdreg(pwm_cmp_pkg::A_STAT, rd);
    lperiod(0, 0);
    chk("R8 masked irq", int'(irq_o), 0);
    wr(pwm_cmp_pkg::A_IEN, (CW+1)'(1));
    chk("R8 irq enabled", int'(irq_o), 1);
    rdreg(pwm_cmp_pkg::A_STAT, rd); chk("R9 status match bit", int'(rd), 1);
    chk("R9 irq after read", int'(irq_o), 0);
    rdreg(pwm_cmp_pkg::A_STAT, rd); chk("R9 status cleared", int'(rd), 0);
    lperiod(0, 0);
    chk("R8 irq on match", int'(irq_o), 1);
    wr(pwm_cmp_pkg::A_IDIS, (CW+1)'(1));
    chk("R8 irq disabled", int'(irq_o), 0);
    rdreg(pwm_cmp_pkg::A_MASK, rd); chk("R8 mask cleared", int'(rd), 0);
    wr(pwm_cmp_pkg::A_IEN, (CW+1)'(2));
    chk("R8 no update yet", int'(irq_o), 0);
    wr(pwm_cmp_pkg::A_CFG, cfgw(1, 0, 0, 0));
    flush();
    chk("R8 irq on update", int'(irq_o), 1);
    rdreg(pwm_cmp_pkg::A_STAT, rd); chk("R9 both bits", int'(rd), 3);
    chk("R9 irq cleared", int'(irq_o), 0);

    // R1 disabled unit never matches
    wr(pwm_cmp_pkg::A_CFG, cfgw(0, 0, 0, 0));
    flush();
    m0 = mcount; lperiod(0, 0); lperiod(0, 0);
    chk("R1 disabled no match", mcount - m0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule